// File: doc/BRIEF.md
# Serial-Loaded Multichannel Converter Code Register

This block is the digital front end of a multichannel digital-to-analog converter that takes its codes over a single serial line. A host drives a data bit, a serial clock and an active-low enable. While the enable is low, each falling edge of the serial clock moves one bit into a long shift register, most significant bit first. When the enable goes high again, the whole shift register is copied at once into a bank of per-channel holding registers. The held codes appear as parallel words, one per channel, and the analog ladder that would use them sits outside this block.

The serial clock passes through a gate that follows it while the enable is low and freezes its last value while the enable is high. Clock activity during the idle phase therefore cannot disturb the shift register. The bit that leaves the far end of the shift register is driven on a serial output, so the data input of a second device can be fed from it and several devices can share one load cycle. All pins are sampled on a fast system clock, which also carries every register.

Top module: `dac_serial_bank`

## Requirements
- R1: During and right after reset, every channel code and the serial output are zero.
- R2: A falling edge of the gated serial clock shifts the data input into bit 0 of the shift register. A code is sent most significant bit first.
- R3: A rising edge of the serial clock shifts nothing.
- R4: The word shifted in last lands in channel 1, and the word before it lands in channel 2, and so on. The output bus carries channel k in bits [6k-1:6k-6].
- R5: The channel codes change only on a low-to-high transition of the enable. They hold their value at every other time, including during a serial load.
- R6: Serial clock edges while the enable is high leave the shift register unchanged.
- R7: While the enable is high, the gated clock keeps the value it had when the enable rose. If that value is high and the serial clock is low when the enable falls, exactly one shift happens at that fall.
- R8: A load of fewer than N words gives channels 1 to k the k new words. Each higher channel receives the contents of the channel k places below it.
- R9: At each shift, the serial output takes the bit that leaves the top of the shift register (bit 6N-1). That is the bit shifted in 6N shifts earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; shifts on its falling edge |
| ser_en_n | input | 1 | Active-low load enable; its rising edge transfers the codes |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output for chaining |
| chan_code | output | NUM_CH*CODE_W | Held channel codes; channel 1 is in the lowest bits |

## Verification
The hardest case to reach is an enable fall while the serial clock is already low. It only matters when the gate froze a high value at the previous enable rise. The bench reaches it in steps. It raises the enable with the clock high, toggles the clock while enabled-high, parks the clock low, and then drops the enable. A following transfer shows whether exactly one bit entered. A second sequence toggles the clock while the enable is high and then transfers with no clocks at all. This proves that the shift register did not move.

// File: rtl/dac_pkg.sv
package dac_pkg;
    localparam int unsigned DEF_CODE_W = 6;
    localparam int unsigned DEF_NUM_CH = 6;

    typedef struct packed {
        logic gate;
        logic en_prev;
    } gate_state_t;
endpackage

// File: rtl/dac_clk_gate.sv
module dac_clk_gate
    import dac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_en_n,
    output logic shift_pulse,
    output logic load_pulse
);
    gate_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.gate    = ser_en_n ? st_q.gate : ser_clk;
        st_d.en_prev = ser_en_n;
        shift_pulse  = st_q.gate & ~st_d.gate;
        load_pulse   = ser_en_n & ~st_q.en_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gate    <= 1'b1;
            st_q.en_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dac_shift_chain.sv
module dac_shift_chain #(
    parameter int unsigned DEPTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             din,
    output logic [DEPTH-1:0] sreg,
    output logic             dout
);
    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic             dout;
    } chain_t;

    chain_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (shift) begin
            ch_d.dout = ch_q.bits[DEPTH-1];
            ch_d.bits = {ch_q.bits[DEPTH-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign sreg = ch_q.bits;
    assign dout = ch_q.dout;
endmodule

// File: rtl/dac_hold_bank.sv
module dac_hold_bank #(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned CODE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NUM_CH*CODE_W-1:0] sreg,
    output logic [NUM_CH*CODE_W-1:0] codes
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CODE_W-1:0] code_d, code_q;

        always_comb begin
            code_d = code_q;
            if (load) begin
                code_d = sreg[g*CODE_W +: CODE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q <= '0;
            end else begin
                code_q <= code_d;
            end
        end

        assign codes[g*CODE_W +: CODE_W] = code_q;
    end
endmodule

// File: rtl/dac_serial_bank.sv
module dac_serial_bank
    import dac_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned CODE_W = DEF_CODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_en_n,
    input  logic                     ser_din,
    output logic                     ser_dout,
    output logic [NUM_CH*CODE_W-1:0] chan_code
);
    localparam int unsigned TOTAL_W = NUM_CH * CODE_W;

    logic               shift_pulse;
    logic               load_pulse;
    logic [TOTAL_W-1:0] sreg;

    dac_clk_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_en_n   (ser_en_n),
        .shift_pulse(shift_pulse),
        .load_pulse (load_pulse)
    );

    dac_shift_chain #(.DEPTH(TOTAL_W)) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .shift(shift_pulse),
        .din  (ser_din),
        .sreg (sreg),
        .dout (ser_dout)
    );

    dac_hold_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load_pulse),
        .sreg (sreg),
        .codes(chan_code)
    );
endmodule

// File: rtl/dac_serial_bank_chk.sv
module dac_serial_bank_chk #(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned CODE_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ser_en_n,
    input logic                     ser_dout,
    input logic [NUM_CH*CODE_W-1:0] chan_code
);
    // R1: reset clears the outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (chan_code == '0 && ser_dout == 1'b0));

    // R5: no code change while loading
    assert_hold_during_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en_n |=> $stable(chan_code));

    // R5: no code change while idle after a transfer
    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en_n && $past(ser_en_n)) |=> $stable(chan_code));

    // R6: serial output frozen while enable is high
    assert_no_shift_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en_n |=> $stable(ser_dout));
endmodule

bind dac_serial_bank dac_serial_bank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_en_n (ser_en_n),
    .ser_dout (ser_dout),
    .chan_code(chan_code)
);

// File: tb/test_dac_serial_bank.sv
module test_dac_serial_bank;
    localparam int NCH = 6;
    localparam int CW  = 6;
    localparam int TW  = NCH * CW;
    localparam int NV  = 4;

    // stimulus: packed words (word 0 sent last) and word count; expected codes come from the model
    localparam logic [TW-1:0] VEC [NV] = '{
        36'hA5C_3F0_91E,
        36'h123_456_789,
        36'hFED_CBA_987,
        36'h000_000_02B
    };
    localparam int NW [NV] = '{6, 6, 3, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1;
    logic ser_en_n = 1'b1;
    logic ser_din = 1'b0;
    logic ser_dout;
    logic [TW-1:0] chan_code;

    int total = 0;
    int bad = 0;
    logic [TW-1:0] m_sreg = '0;
    logic [TW-1:0] m_hold = '0;
    logic m_dout = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    dac_serial_bank i_dac_serial_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_en_n (ser_en_n),
        .ser_din  (ser_din),
        .ser_dout (ser_dout),
        .chan_code(chan_code)
    );

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;
        ser_clk = 1'b0;
        wait_n(2);
        m_dout = m_sreg[TW-1];
        m_sreg = {m_sreg[TW-2:0], b};
        check("R9 dout after shift", {{(TW-1){1'b0}}, ser_dout}, {{(TW-1){1'b0}}, m_dout});
        ser_clk = 1'b1;
        wait_n(2);
        check("R3 no shift on rise", {{(TW-1){1'b0}}, ser_dout}, {{(TW-1){1'b0}}, m_dout});
    endtask

    task automatic transfer(input string req);
        ser_en_n = 1'b1;
        wait_n(2);
        m_hold = m_sreg;
        check(req, chan_code, m_hold);
    endtask

    initial begin
        wait_n(3);
        check("R1 reset codes", chan_code, '0);
        check("R1 reset dout", {{(TW-1){1'b0}}, ser_dout}, '0);
        rst_n = 1'b1;
        wait_n(2);

        // table walk: R2, R4, R8
        for (int v = 0; v < NV; v++) begin
            ser_en_n = 1'b0;
            wait_n(2);
            for (int w = NW[v] - 1; w >= 0; w--) begin
                for (int b = CW - 1; b >= 0; b--) begin
                    send_bit(VEC[v][w*CW + b]);
                end
            end
            check("R5 codes held during load", chan_code, m_hold);
            transfer(NW[v] == NCH ? "R4 full load mapping" : "R8 partial load");
            if (v == 0) check("R2 channel 1 msb-first", {30'b0, chan_code[5:0]}, {30'b0, 6'h1E});
            wait_n(10);
            check("R5 codes held idle", chan_code, m_hold);
        end

        // R6: clock toggling while enable high, clock left high, then a bare enable pulse
        for (int i = 0; i < 3; i++) begin
            ser_clk = 1'b0; wait_n(2);
            ser_clk = 1'b1; wait_n(2);
        end
        ser_en_n = 1'b0;
        wait_n(2);
        check("R6 no shift while idle dout", {{(TW-1){1'b0}}, ser_dout}, {{(TW-1){1'b0}}, m_dout});
        transfer("R6 shift register unchanged");

        // R7: latch held high, clock parked low, enable falls
        ser_clk = 1'b0; wait_n(2);
        ser_clk = 1'b1; wait_n(2);
        ser_clk = 1'b0; wait_n(2);
        ser_din = 1'b1;
        ser_en_n = 1'b0;
        wait_n(2);
        m_dout = m_sreg[TW-1];
        m_sreg = {m_sreg[TW-2:0], 1'b1};
        check("R7 dout after enable fall", {{(TW-1){1'b0}}, ser_dout}, {{(TW-1){1'b0}}, m_dout});
        ser_clk = 1'b1;
        wait_n(2);
        transfer("R7 exactly one shift");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule